// File: doc/BRIEF.md
# Core Restart Loader

This block restarts a processor core, reloading only as much of the core's local program memory as the caller asks for. A restart command carries three things: the address in shared memory where the code image begins, the number of 32-bit words (or `DATA_W`-bit words) to copy, and the address at which the core resumes execution. An optional flag requests that the core's register state be cleared at the moment of restart.

When the word count is non-zero, the controller holds the core stopped. It fetches the words one at a time over a valid/ready read port and writes them to local memory from address 0 upward. It then loads the program counter and releases the core. Copying only the needed words is quicker than a full image reload. Because the resume address is free, it can index a table of jumps at the head of resident code, so one loaded image can serve several entry routines.

A zero word count copies nothing and leaves registers untouched. Only the program counter is set before the core runs again. Counts above the local memory size are limited to that size.

Top module: `core_restart_loader`

## Requirements
- R1: Out of reset, `busy`, `core_run`, `rd_valid`, `lm_we`, `pc_load` and `reg_clear` are all low.
- R2: A command presented with `cmd_valid` while `busy` is low is accepted at that clock edge. From the next cycle, `busy` is high and `core_run` is low until the restart completes.
- R3: While `busy` is high, `cmd_valid` is ignored. The restart in progress keeps its original resume address and word count.
- R4: For a non-zero count N, exactly N words are written. Word i is read from shared address `cmd_src_addr + i` and written to local address i, with `lm_wdata` equal to the `rd_data` returned for it.
- R5: A local write happens only in a cycle where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_addr` holds and no write occurs.
- R6: The cycle after the last write, `pc_load` is high for exactly one cycle with `pc_value` equal to the command's resume address. In the following cycle, `busy` is low and `core_run` is high.
- R7: A count of 0 raises neither `rd_valid` nor `lm_we`. `pc_load` rises in the cycle right after acceptance.
- R8: `reg_clear` pulses together with `pc_load` only when the command's clear flag is set and its count is non-zero (and the `CLEAR_EN` option is on). Otherwise it stays low.
- R9: A count above `MAX_WORDS` is treated as `MAX_WORDS`.
- R10: Once released, `core_run` stays high until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Restart command strobe |
| cmd_src_addr | input | SA_W | Shared-memory address of the first word |
| cmd_len | input | LEN_W | Number of words to copy (0 = set PC only) |
| cmd_start | input | PC_W | Resume address for the core |
| cmd_clear | input | 1 | Request register clear on restart |
| busy | output | 1 | Restart in progress |
| rd_valid | output | 1 | Shared-memory read request |
| rd_addr | output | SA_W | Shared-memory read address |
| rd_ready | input | 1 | Read accepted, `rd_data` valid this cycle |
| rd_data | input | DATA_W | Read data |
| lm_we | output | 1 | Local memory write enable |
| lm_addr | output | LA_W | Local memory write address |
| lm_wdata | output | DATA_W | Local memory write data |
| core_run | output | 1 | Core allowed to execute |
| pc_load | output | 1 | Load the program counter |
| pc_value | output | PC_W | Value for the program counter |
| reg_clear | output | 1 | Clear core registers |

## Verification
The hardest case to reach from the ports is a second command arriving while a restart is in flight, timed against a read port that stalls. The stimulus sweeps every word count from 0 past the clamp limit, with three `rd_ready` patterns (always ready, every other cycle, every third cycle). In the stalling runs, it presents a conflicting command in the first busy cycle. Each run then checks that the write count and resume address belong to the first command.

// File: rtl/crl_pkg.sv
package crl_pkg;
   typedef enum logic [1:0] {
      CRL_IDLE  = 2'd0,
      CRL_LOAD  = 2'd1,
      CRL_START = 2'd2
   } crl_state_e;
endpackage

// File: rtl/crl_counter.sv
module crl_counter #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   input  logic [CW-1:0] target,
   output logic [CW-1:0] cnt,
   output logic          last
);
   logic [CW-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q + 1'b1;
   end

   assign cnt  = q;
   assign last = (({1'b0, q} + 1'b1) == {1'b0, target});

   AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      inc |-> (q < target)); // R9
endmodule

// File: rtl/crl_fsm.sv
module crl_fsm
   import crl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic       len_zero,
   input  logic       xfer,
   input  logic       last,
   output crl_state_e state
);
   crl_state_e nxt;

   always_comb begin
      nxt = state;
      case (state)
         CRL_IDLE:  if (accept) nxt = len_zero ? CRL_START : CRL_LOAD;
         CRL_LOAD:  if (xfer && last) nxt = CRL_START;
         CRL_START: nxt = CRL_IDLE;
         default:   nxt = CRL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= CRL_IDLE;
      else        state <= nxt;
   end

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CRL_START) |=> (state == CRL_IDLE)); // R6
endmodule

// File: rtl/core_restart_loader.sv
module core_restart_loader
   import crl_pkg::*;
#(
   parameter int SA_W      = 16,
   parameter int DATA_W    = 32,
   parameter int MAX_WORDS = 496,
   parameter int LEN_W     = 10,
   parameter int PC_W      = 9,
   parameter int LA_W      = $clog2(MAX_WORDS),
   parameter bit CLEAR_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [SA_W-1:0]   cmd_src_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic [PC_W-1:0]   cmd_start,
   input  logic              cmd_clear,
   output logic              busy,
   output logic              rd_valid,
   output logic [SA_W-1:0]   rd_addr,
   input  logic              rd_ready,
   input  logic [DATA_W-1:0] rd_data,
   output logic              lm_we,
   output logic [LA_W-1:0]   lm_addr,
   output logic [DATA_W-1:0] lm_wdata,
   output logic              core_run,
   output logic              pc_load,
   output logic [PC_W-1:0]   pc_value,
   output logic              reg_clear
);
   localparam int CW = $clog2(MAX_WORDS + 1);

   if (MAX_WORDS < 2) begin : g_bad_depth
      $error("MAX_WORDS must be at least 2");
   end
   if (LEN_W < CW) begin : g_bad_len
      $error("LEN_W too narrow for MAX_WORDS");
   end
   if (LA_W < $clog2(MAX_WORDS)) begin : g_bad_la
      $error("LA_W too narrow for MAX_WORDS");
   end
   if (SA_W < CW) begin : g_bad_sa
      $error("SA_W narrower than word counter");
   end

   crl_state_e        state;
   logic              accept, xfer, last;
   logic [CW-1:0]     len_c, len_q, cnt;
   logic [SA_W-1:0]   src_q;
   logic [PC_W-1:0]   start_q;
   logic              clr_q;

   assign busy   = (state != CRL_IDLE);
   assign accept = cmd_valid && !busy;
   assign len_c  = (cmd_len > LEN_W'(MAX_WORDS)) ? CW'(MAX_WORDS) : CW'(cmd_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= '0;
         start_q <= '0;
         len_q   <= '0;
         clr_q   <= 1'b0;
      end else if (accept) begin
         src_q   <= cmd_src_addr;
         start_q <= cmd_start;
         len_q   <= len_c;
         clr_q   <= cmd_clear;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  core_run <= 1'b0;
      else if (accept)             core_run <= 1'b0;
      else if (state == CRL_START) core_run <= 1'b1;
   end

   crl_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .len_zero (len_c == '0),
      .xfer     (xfer),
      .last     (last),
      .state    (state)
   );

   crl_counter #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .inc    (xfer),
      .target (len_q),
      .cnt    (cnt),
      .last   (last)
   );

   assign rd_valid = (state == CRL_LOAD);
   assign rd_addr  = src_q + SA_W'(cnt);
   assign xfer     = rd_valid && rd_ready;
   assign lm_we    = xfer;
   assign lm_addr  = LA_W'(cnt);
   assign lm_wdata = rd_data;
   assign pc_load  = (state == CRL_START);
   assign pc_value = start_q;

   if (CLEAR_EN) begin : g_clear
      assign reg_clear = pc_load && clr_q && (len_q != '0);
   end else begin : g_noclear
      assign reg_clear = 1'b0;
   end

   AST_RUN_OFF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !core_run); // R2
   AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(start_q) && $stable(len_q)); // R3
   AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_valid && !lm_we); // R7
   AST_HOLD_ADDR_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr)); // R5
   AST_RUN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> core_run && !busy); // R6
   AST_CLEAR_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      reg_clear |-> pc_load && !core_run); // R8
   AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (core_run && !cmd_valid) |=> core_run); // R10
endmodule

// File: tb/sim_core_restart_loader.sv
module sim_core_restart_loader;
   localparam int CLK_PERIOD = 10;
   localparam int SA_W = 8, DATA_W = 16, MAXW = 6, LEN_W = 4, PC_W = 5;
   localparam int LA_W = $clog2(MAXW);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_clear = 1'b0, rd_ready = 1'b0;
   logic [SA_W-1:0] cmd_src_addr = '0;
   logic [LEN_W-1:0] cmd_len = '0;
   logic [PC_W-1:0] cmd_start = '0;
   logic busy, rd_valid, lm_we, core_run, pc_load, reg_clear;
   logic [SA_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data, lm_wdata;
   logic [LA_W-1:0] lm_addr;
   logic [PC_W-1:0] pc_value;

   int checks = 0, failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DATA_W-1:0] memf(input logic [SA_W-1:0] a);
      return DATA_W'(int'(a) * 37 + 5) ^ 16'h5A00;
   endfunction
   assign rd_data = memf(rd_addr);

   core_restart_loader #(.SA_W(SA_W), .DATA_W(DATA_W), .MAX_WORDS(MAXW),
      .LEN_W(LEN_W), .PC_W(PC_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src_addr(cmd_src_addr),
      .cmd_len(cmd_len), .cmd_start(cmd_start), .cmd_clear(cmd_clear), .busy(busy),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
      .lm_we(lm_we), .lm_addr(lm_addr), .lm_wdata(lm_wdata), .core_run(core_run),
      .pc_load(pc_load), .pc_value(pc_value), .reg_clear(reg_clear));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_cmd(input int src, input int start, input int len, input bit clr,
                          input int mode, input bit inject);
      int exp_n, writes;
      bit saw_read, found;
      exp_n = (len > MAXW) ? MAXW : len;
      @(negedge clk);
      cmd_src_addr = SA_W'(src); cmd_start = PC_W'(start);
      cmd_len = LEN_W'(len); cmd_clear = clr; cmd_valid = 1'b1;
      writes = 0; saw_read = 0; found = 0;
      for (int i = 0; i < 200 && !found; i++) begin
         @(negedge clk);
         if (inject && i == 0) begin
            cmd_start = PC_W'(start + 1); cmd_len = LEN_W'((len + 2) % 8); cmd_valid = 1'b1;
         end else cmd_valid = 1'b0;
         rd_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (i % 2 == 1) : (i % 3 == 2);
         #1;
         if (i == 0) chk(busy && !core_run, "R2", {busy, core_run}, 2);
         if (rd_valid) saw_read = 1;
         if (lm_we) begin
            chk(rd_ready, "R5", rd_ready, 1);
            chk(lm_addr == LA_W'(writes), "R4", lm_addr, writes);
            chk(rd_addr == SA_W'(src + writes), "R4", rd_addr, src + writes);
            chk(lm_wdata == memf(SA_W'(src + writes)), "R4", lm_wdata, memf(SA_W'(src + writes)));
            writes++;
         end
         if (pc_load) begin
            found = 1;
            chk(pc_value == PC_W'(start), inject ? "R3" : "R6", pc_value, start);
            chk(writes == exp_n, (len > MAXW) ? "R9" : (inject ? "R3" : "R4"), writes, exp_n);
            chk(reg_clear == (clr && len != 0), "R8", reg_clear, clr && len != 0);
            chk(saw_read == (len != 0), "R7", saw_read, len != 0);
            if (len == 0) chk(i == 0, "R7", i, 0);
         end
      end
      chk(found, "R6", found, 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
      chk(!busy && core_run && !pc_load, "R6", {busy, core_run, pc_load}, 2);
      @(negedge clk); #1;
      chk(core_run && !busy, "R10", {core_run, busy}, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !core_run && !rd_valid && !lm_we && !pc_load && !reg_clear, "R1",
          {busy, core_run, rd_valid, lm_we, pc_load, reg_clear}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int len = 0; len <= 8; len++)
         for (int mode = 0; mode < 3; mode++)
            for (int clr = 0; clr < 2; clr++)
               run_cmd(len * 11 + mode, (len * 5 + mode * 3 + clr) % 30, len, clr[0],
                       mode, mode != 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule